// File: doc/BRIEF.md
# Descriptor-Ring DMA Channel

One DMA channel that moves data from memory to memory by following a ring of descriptors stored in that same memory. Each descriptor is eight 32-bit words on a 32-byte boundary. It holds a flags word, the pointer to the next descriptor, a byte count, a source and a destination address, one addressing attribute word per side, and a status word. Software owns a descriptor while its valid flag is clear. Setting the flag hands the descriptor to the engine. The engine clears the flag again when the copy is done.

Software loads the descriptor pointer, sets the enable bit and writes the doorbell. The engine then fetches descriptors and copies data one 32-bit word per beat, reading each word from the source and then writing it to the destination. It uses a single memory port for both the descriptor traffic and the data beats. When it reaches a descriptor that software has not yet handed over, it parks until the next doorbell. When enable is cleared, the engine finishes the bus beat in progress, stops, and reports halted, so software can read the residual byte count.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset the status register reads 1 (halted), the interrupt is low, no memory request is issued, and the pointer and residual count registers read 0.
- R2: A pointer register write (register 1) is accepted only while halted, and its five low bits are forced to zero. After enable (register 0 bit 0) and a write of any value to the doorbell (register 2), the engine starts fetching at that pointer.
- R3: Descriptor word offsets are: 0 flags (bit 0 valid, bit 1 interrupt enable), 1 next pointer, 2 byte count, 3 source address, 4 destination address, 5 source attribute, 6 destination attribute, 7 status.
- R4: For an incrementing side, the address advances by 4 after every word. A byte count of N (a multiple of 4) moves N/4 words, each read from the source and then written to the destination.
- R5: An attribute word with bits [1:0] = 1 selects static mode, which reuses one address for every beat. The codes 0 and 2 both increment.
- R6: On completion the engine writes 0x00000001 to the status word (offset 7). It then writes the flags word back with bit 0 cleared and all other bits unchanged, and continues at the next pointer, so a ring wraps from its last entry back to its first.
- R7: When the fetched flags word has bit 0 clear, the engine issues no further memory requests and does not report halted. A later doorbell write makes it fetch the same descriptor again.
- R8: Completing a descriptor whose flags bit 1 is set raises irq, and irq stays high until any write to register 4 clears it. A descriptor with bit 1 clear leaves irq unchanged.
- R9: Clearing enable lets the current memory beat finish. After that the engine issues no new request and status bit 0 (halted) reads 1.
- R10: Status bit 1 shows a pending doorbell and bit 2 shows that a valid descriptor is in progress. Writing a 1 to either bit of register 3 clears that bit.
- R11: Register 5 holds the bytes not yet written for the current descriptor. Each acknowledged destination write lowers it by 4.
- R12: While mem_req is high and mem_ack is low, the request, address, write flag and write data hold their values into the next cycle.
- R13: A descriptor with a byte count of 0 moves no data but is still completed as in R6 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | 32 | Read data, valid in the cycle of mem_ack |
| irq | output | 1 | Channel interrupt |

## Verification
A register write takes effect at the clock edge that samples it, so irq clearing, doorbell pending and the W1C status bits are checked at the next falling edge. The time a descriptor takes depends on the memory latency, which the bench varies. Completion, parking on an invalid descriptor and halting are therefore found by bounded polling: the bench waits for the request line to stay idle for 16 cycles, or for the halted bit, and only then compares memory contents, flags and status words against values it computes from the descriptor fields. The residual count is compared with the byte count minus four times the destination writes that the bench's memory model acknowledged before the halt.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam int DESC_WORDS = 8;
  localparam int DESC_ALIGN = $clog2(DESC_WORDS * 4);

  typedef logic [2:0] dword_t;

  // register indices
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_PTR   = 3'd1;
  localparam logic [2:0] RA_BELL  = 3'd2;
  localparam logic [2:0] RA_STAT  = 3'd3;
  localparam logic [2:0] RA_IRQ   = 3'd4;
  localparam logic [2:0] RA_RESID = 3'd5;

  // status bit positions
  localparam int ST_HALT_BIT = 0;
  localparam int ST_BELL_BIT = 1;
  localparam int ST_CURV_BIT = 2;

  // flags word bit positions
  localparam int FL_VALID = 0;
  localparam int FL_IE    = 1;

  // descriptor word offsets
  localparam dword_t DW_FLAGS = 3'd0;
  localparam dword_t DW_NEXT  = 3'd1;
  localparam dword_t DW_COUNT = 3'd2;
  localparam dword_t DW_SRC   = 3'd3;
  localparam dword_t DW_DST   = 3'd4;
  localparam dword_t DW_SATTR = 3'd5;
  localparam dword_t DW_DATTR = 3'd6;
  localparam dword_t DW_STAT  = 3'd7;

  typedef enum logic [1:0] {
    AM_INC    = 2'd0,
    AM_STATIC = 2'd1,
    AM_BURST  = 2'd2,
    AM_RSVD   = 2'd3
  } addr_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_FETCH,
    S_RD,
    S_WR,
    S_STAT,
    S_FLAG
  } seq_state_e;
endpackage

// File: rtl/ring_dma_agen.sv
module ring_dma_agen
  import ring_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_mode,
  input  logic          step,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] WORD_BYTES = AW'(4);

  logic [AW-1:0] addr_q, addr_d;
  addr_mode_e    mode_q, mode_d;

  always_comb begin
    addr_d = addr_q;
    mode_d = mode_q;
    if (ld_mode) mode_d = addr_mode_e'(din[1:0]);
    if (ld_addr) begin
      addr_d = din;
    end else if (step && (mode_q != AM_STATIC)) begin
      addr_d = addr_q + WORD_BYTES;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= AM_INC;
    end else begin
      if (ld_addr || step) addr_q <= addr_d;
      if (ld_mode)         mode_q <= mode_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [2:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   halted,
  input  logic                   cur_valid,
  input  logic [AW-1:0]          cur_ptr,
  input  logic [CW-1:0]          resid,
  input  logic                   bell_take,
  input  logic                   irq_set,
  output logic                   en,
  output logic                   bell_pend,
  output logic                   irq,
  output logic                   ptr_wr,
  output logic [AW-1:DESC_ALIGN] ptr_wdata,
  output logic                   clr_curv
);
  logic en_q, en_d;
  logic bell_q, bell_d;
  logic irq_q, irq_d;
  logic wr_ctrl, wr_bell, wr_stat, wr_irq;
  logic unused_wbits;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_bell = reg_wr && (reg_addr == RA_BELL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_irq  = reg_wr && (reg_addr == RA_IRQ);

  assign unused_wbits = ^reg_wdata[DESC_ALIGN-1:3];

  always_comb begin
    en_d = en_q;
    if (wr_ctrl) en_d = reg_wdata[0];

    bell_d = bell_q;
    if (bell_take || (wr_stat && reg_wdata[ST_BELL_BIT])) bell_d = 1'b0;
    if (wr_bell) bell_d = 1'b1;

    irq_d = irq_q;
    if (wr_irq)  irq_d = 1'b0;
    if (irq_set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      bell_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= en_d;
      if (wr_bell || wr_stat || bell_take) bell_q <= bell_d;
      if (wr_irq || irq_set) irq_q <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL:  reg_rdata[0] = en_q;
      RA_PTR:   reg_rdata = 32'(cur_ptr);
      RA_STAT: begin
        reg_rdata[ST_HALT_BIT] = halted;
        reg_rdata[ST_BELL_BIT] = bell_q;
        reg_rdata[ST_CURV_BIT] = cur_valid;
      end
      RA_IRQ:   reg_rdata[0] = irq_q;
      RA_RESID: reg_rdata = 32'(resid);
      default:  reg_rdata = '0;
    endcase
  end

  assign en        = en_q;
  assign bell_pend = bell_q;
  assign irq       = irq_q;
  assign ptr_wr    = reg_wr && (reg_addr == RA_PTR);
  assign ptr_wdata = reg_wdata[AW-1:DESC_ALIGN];
  assign clr_curv  = wr_stat && reg_wdata[ST_CURV_BIT];
endmodule

// File: rtl/ring_dma_seq.sv
module ring_dma_seq
  import ring_dma_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          CW        = 16,
  parameter logic [31:0] DONE_CODE = 32'h0000_0001
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   bell_pend,
  input  logic                   ptr_wr,
  input  logic [AW-1:DESC_ALIGN] ptr_wdata,
  input  logic                   clr_curv,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [31:0]            mem_wdata,
  input  logic                   mem_ack,
  input  logic [31:0]            mem_rdata,
  output logic                   halted,
  output logic                   cur_valid,
  output logic [AW-1:0]          cur_ptr,
  output logic [CW-1:0]          resid,
  output logic                   bell_take,
  output logic                   irq_set
);
  localparam int              SIDES      = 2;
  localparam int              SIDE_SRC   = 0;
  localparam int              SIDE_DST   = 1;
  localparam dword_t          LAST_FETCH = DW_DATTR;
  localparam logic [CW-1:0]   BEAT_BYTES = CW'(4);

  seq_state_e                state_q, state_d;
  dword_t                    widx_q, widx_d;
  logic [AW-1:DESC_ALIGN]    ptr_q, ptr_d;
  logic [AW-1:DESC_ALIGN]    next_q, next_d;
  logic [31:0]               flags_q, flags_d;
  logic [CW-1:0]             cnt_q, cnt_d;
  logic [31:0]               data_q, data_d;
  logic                      curv_q, curv_d;

  logic [SIDES-1:0]          ld_addr, ld_mode;
  logic                      step;
  logic [AW-1:0]             side_addr [SIDES];

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    ring_dma_agen #(.AW(AW)) u_agen (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_addr (ld_addr[s]),
      .ld_mode (ld_mode[s]),
      .step    (step),
      .din     (mem_rdata[AW-1:0]),
      .addr    (side_addr[s])
    );
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    widx_d    = widx_q;
    ptr_d     = ptr_q;
    next_d    = next_q;
    flags_d   = flags_q;
    cnt_d     = cnt_q;
    data_d    = data_q;
    curv_d    = curv_q;
    bell_take = 1'b0;
    irq_set   = 1'b0;
    step      = 1'b0;
    ld_addr   = '0;
    ld_mode   = '0;

    if (clr_curv) curv_d = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (ptr_wr) ptr_d = ptr_wdata;
        if (en && bell_pend) begin
          bell_take = 1'b1;
          widx_d    = DW_FLAGS;
          state_d   = S_FETCH;
        end
      end
      S_WAIT: begin
        if (!en) begin
          state_d = S_IDLE;
        end else if (bell_pend) begin
          bell_take = 1'b1;
          widx_d    = DW_FLAGS;
          state_d   = S_FETCH;
        end
      end
      S_FETCH: begin
        if (mem_ack) begin
          unique case (widx_q)
            DW_FLAGS: flags_d = mem_rdata;
            DW_NEXT:  next_d  = mem_rdata[AW-1:DESC_ALIGN];
            DW_COUNT: cnt_d   = mem_rdata[CW-1:0];
            DW_SRC:   ld_addr[SIDE_SRC] = 1'b1;
            DW_DST:   ld_addr[SIDE_DST] = 1'b1;
            DW_SATTR: ld_mode[SIDE_SRC] = 1'b1;
            DW_DATTR: ld_mode[SIDE_DST] = 1'b1;
            default:  ;
          endcase
          widx_d = widx_q + 3'd1;
          if ((widx_q == DW_FLAGS) && mem_rdata[FL_VALID]) curv_d = 1'b1;
          if (!en) begin
            state_d = S_IDLE;
          end else if ((widx_q == DW_FLAGS) && !mem_rdata[FL_VALID]) begin
            state_d = S_WAIT;
          end else if (widx_q == LAST_FETCH) begin
            state_d = (cnt_q == '0) ? S_STAT : S_RD;
          end
        end
      end
      S_RD: begin
        if (mem_ack) begin
          data_d  = mem_rdata;
          state_d = en ? S_WR : S_IDLE;
        end
      end
      S_WR: begin
        if (mem_ack) begin
          step  = 1'b1;
          cnt_d = (cnt_q > BEAT_BYTES) ? (cnt_q - BEAT_BYTES) : '0;
          if (!en)                       state_d = S_IDLE;
          else if (cnt_q <= BEAT_BYTES)  state_d = S_STAT;
          else                           state_d = S_RD;
        end
      end
      S_STAT: begin
        if (mem_ack) state_d = en ? S_FLAG : S_IDLE;
      end
      S_FLAG: begin
        if (mem_ack) begin
          ptr_d   = next_q;
          irq_set = flags_q[FL_IE];
          curv_d  = 1'b0;
          widx_d  = DW_FLAGS;
          state_d = en ? S_FETCH : S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      widx_q  <= DW_FLAGS;
      ptr_q   <= '0;
      next_q  <= '0;
      flags_q <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      curv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      curv_q  <= curv_d;
      if (mem_ack || state_q == S_IDLE || state_q == S_WAIT) begin
        widx_q  <= widx_d;
        ptr_q   <= ptr_d;
        next_q  <= next_d;
        flags_q <= flags_d;
        cnt_q   <= cnt_d;
        data_q  <= data_d;
      end
    end
  end

  // memory port drive, held steady by the registered state
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {ptr_q, DW_FLAGS, 2'b00};
    mem_wdata = data_q;
    unique case (state_q)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = {ptr_q, widx_q, 2'b00};
      end
      S_RD: begin
        mem_req  = 1'b1;
        mem_addr = side_addr[SIDE_SRC];
      end
      S_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = side_addr[SIDE_DST];
      end
      S_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {ptr_q, DW_STAT, 2'b00};
        mem_wdata = DONE_CODE;
      end
      S_FLAG: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {ptr_q, DW_FLAGS, 2'b00};
        mem_wdata = flags_q & ~(32'h1 << FL_VALID);
      end
      default: ;
    endcase
  end

  assign halted    = (state_q == S_IDLE);
  assign cur_valid = curv_q;
  assign cur_ptr   = {ptr_q, {DESC_ALIGN{1'b0}}};
  assign resid     = cnt_q;
endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
  import ring_dma_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          CW        = 16,
  parameter logic [31:0] DONE_CODE = 32'h0000_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  logic [1:0]             rst_pipe;
  logic                   rst_q_n;
  logic                   en, bell_pend, bell_take, irq_set;
  logic                   halted, cur_valid, ptr_wr, clr_curv;
  logic [AW-1:0]          cur_ptr;
  logic [CW-1:0]          resid;
  logic [AW-1:DESC_ALIGN] ptr_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  ring_dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .halted    (halted),
    .cur_valid (cur_valid),
    .cur_ptr   (cur_ptr),
    .resid     (resid),
    .bell_take (bell_take),
    .irq_set   (irq_set),
    .en        (en),
    .bell_pend (bell_pend),
    .irq       (irq),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (ptr_wdata),
    .clr_curv  (clr_curv)
  );

  ring_dma_seq #(.AW(AW), .CW(CW), .DONE_CODE(DONE_CODE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .en        (en),
    .bell_pend (bell_pend),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (ptr_wdata),
    .clr_curv  (clr_curv),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .halted    (halted),
    .cur_valid (cur_valid),
    .cur_ptr   (cur_ptr),
    .resid     (resid),
    .bell_take (bell_take),
    .irq_set   (irq_set)
  );
endmodule

// File: rtl/ring_dma_chan_chk.sv
module ring_dma_chan_chk
  import ring_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          irq,
  input logic          en,
  input logic          bell_pend,
  input logic          halted
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_halted_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);

  assert_no_new_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !mem_req) |=> !mem_req);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_IRQ) && !mem_ack) |=> !irq);

  assert_bell_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == RA_BELL)) |=> bell_pend);
endmodule

bind ring_dma_chan ring_dma_chan_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .irq       (irq),
  .en        (en),
  .bell_pend (bell_pend),
  .halted    (halted)
);

// File: tb/ring_dma_chan_bench.sv
module ring_dma_chan_bench;
  localparam int CLK_P = 10;
  localparam int MEMW  = 1024;
  localparam logic [31:0] PAT = 32'hA500_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;

  logic [31:0] mem [MEMW];
  int lat = 0;
  int wait_c = 0;
  int n_dwr = 0;
  int n_run = 0;
  int n_fail = 0;
  int hold_bad = 0;
  logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0, p_wdata = '0;

  always #(CLK_P/2) clk = ~clk;

  ring_dma_chan u_ring_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  // memory model with programmable wait cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wait_c    <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wait_c >= lat) begin
          wait_c  <= 0;
          mem_ack <= 1'b1;
          if (mem_we) begin
            mem[mem_addr[11:2]] <= mem_wdata;
            if (mem_addr >= 32'h400) n_dwr <= n_dwr + 1;
          end else begin
            mem_rdata <= mem[mem_addr[11:2]];
          end
        end else begin
          wait_c <= wait_c + 1;
        end
      end
    end
  end

  // R12: request held until acknowledged
  always @(negedge clk) begin
    if (rst_n && p_req && !p_ack &&
        !(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata))
      hold_bad <= hold_bad + 1;
    p_req <= mem_req; p_ack <= mem_ack; p_we <= mem_we;
    p_addr <= mem_addr; p_wdata <= mem_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic put_desc(input int base, input logic [31:0] flags, input logic [31:0] nxt,
                          input logic [31:0] cnt, input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] sattr, input logic [31:0] dattr);
    int w;
    w = base >> 2;
    mem[w+0] = flags; mem[w+1] = nxt;  mem[w+2] = cnt;   mem[w+3] = src;
    mem[w+4] = dst;   mem[w+5] = sattr; mem[w+6] = dattr; mem[w+7] = 32'd0;
  endtask

  task automatic wait_quiet(input string tag);
    int q, t;
    q = 0; t = 0;
    while (q < 16 && t < 4000) begin
      @(negedge clk);
      q = mem_req ? 0 : q + 1;
      t++;
    end
    chk(tag, (q >= 16) ? 32'd1 : 32'd0, 32'd1);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int base_w, n_halt, t, busy;
    logic ok;

    for (int i = 0; i < MEMW; i++)
      mem[i] = ((i >= 256 && i < 512) || (i >= 640 && i < 656)) ? PAT + 32'(i) : 32'd0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(3'd3, d); chk("R1 status", d, 32'h1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    rd_reg(3'd1, d); chk("R1 ptr", d, 32'd0);
    rd_reg(3'd5, d); chk("R1 resid", d, 32'd0);

    // R3 three-entry ring: 0x100 -> 0x120 -> 0x140 -> 0x100
    put_desc(32'h100, 32'h3, 32'h120, 16, 32'h400, 32'h800, 32'h0, 32'h2);
    put_desc(32'h120, 32'h1, 32'h140,  8, 32'h440, 32'h840, 32'h1, 32'h0);
    put_desc(32'h140, 32'h3, 32'h100, 12, 32'h480, 32'h880, 32'h0, 32'h1);

    wr_reg(3'd1, 32'h105);
    rd_reg(3'd1, d); chk("R2 pointer low bits forced to zero", d, 32'h100);
    wr_reg(3'd0, 32'h1);
    wr_reg(3'd2, 32'h0);
    wait_quiet("R7 ring parks after wrap");

    ok = 1'b1;
    for (int k = 0; k < 4; k++) if (mem[512+k] !== PAT + 32'(256+k)) ok = 1'b0;
    chk("R4 incrementing copy", {31'd0, ok}, 32'd1);
    chk("R5 static source word0", mem[528], PAT + 32'd272);
    chk("R5 static source word1", mem[529], PAT + 32'd272);
    chk("R5 static destination last", mem[544], PAT + 32'd290);
    chk("R5 static destination untouched", mem[545], 32'd0);
    chk("R4 data write count", 32'(n_dwr), 32'd9);
    chk("R6 flags0 writeback", mem[64], 32'h2);
    chk("R6 flags1 writeback", mem[72], 32'h0);
    chk("R6 flags2 writeback", mem[80], 32'h2);
    chk("R6 status0", mem[71], 32'h1);
    chk("R6 status1", mem[79], 32'h1);
    chk("R6 status2", mem[87], 32'h1);
    rd_reg(3'd1, d); chk("R6 ring wrapped to first", d, 32'h100);
    rd_reg(3'd3, d); chk("R7 waiting is not halted", d, 32'h0);
    chk("R8 irq raised", {31'd0, irq}, 32'd1);
    wr_reg(3'd4, 32'h0);
    chk("R8 irq cleared", {31'd0, irq}, 32'd0);

    // R7 resume: hand back entry 0, no interrupt enable
    put_desc(32'h100, 32'h1, 32'h120, 8, 32'h500, 32'h900, 32'h0, 32'h0);
    wr_reg(3'd2, 32'h5a);
    wait_quiet("R7 resume completes");
    chk("R7 resume word0", mem[576], PAT + 32'd320);
    chk("R7 resume word1", mem[577], PAT + 32'd321);
    chk("R8 no irq without enable", {31'd0, irq}, 32'd0);
    rd_reg(3'd1, d); chk("R7 parked at next entry", d, 32'h120);

    // R13 zero byte count
    base_w = n_dwr;
    put_desc(32'h120, 32'h3, 32'h140, 0, 32'h600, 32'h980, 32'h0, 32'h0);
    wr_reg(3'd2, 32'h0);
    wait_quiet("R13 zero count completes");
    chk("R13 no data beats", 32'(n_dwr - base_w), 32'd0);
    chk("R13 status written", mem[79], 32'h1);
    chk("R13 flags writeback", mem[72], 32'h2);
    chk("R13 irq raised", {31'd0, irq}, 32'd1);
    wr_reg(3'd4, 32'h0);

    // R9 R11 disable mid-transfer with slow memory
    lat = 2;
    base_w = n_dwr;
    put_desc(32'h140, 32'h1, 32'h100, 64, 32'hA00, 32'hC00, 32'h0, 32'h0);
    wr_reg(3'd2, 32'h0);
    t = 0;
    while ((n_dwr - base_w) < 3 && t < 2000) begin @(negedge clk); t++; end
    wr_reg(3'd0, 32'h0);
    t = 0; d = 32'h0;
    while (d[0] !== 1'b1 && t < 100) begin rd_reg(3'd3, d); t++; end
    n_halt = n_dwr - base_w;
    chk("R9 halted with descriptor in progress", d, 32'h5);
    rd_reg(3'd5, d); chk("R11 residual count", d, 32'(64 - 4 * n_halt));
    ok = 1'b1;
    for (int k = 0; k < n_halt; k++) if (mem[768+k] !== PAT + 32'(640+k)) ok = 1'b0;
    chk("R9 beats before halt copied", {31'd0, ok}, 32'd1);
    busy = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (mem_req) busy++; end
    chk("R9 no request after halt", 32'(busy), 32'd0);

    // R10 W1C status bits
    wr_reg(3'd3, 32'h4);
    rd_reg(3'd3, d); chk("R10 clear current-valid", d, 32'h1);
    wr_reg(3'd2, 32'h0);
    busy = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (mem_req) busy++; end
    rd_reg(3'd3, d); chk("R10 doorbell pending while disabled", d, 32'h3);
    chk("R10 no traffic while disabled", 32'(busy), 32'd0);
    wr_reg(3'd3, 32'h2);
    rd_reg(3'd3, d); chk("R10 clear doorbell pending", d, 32'h1);

    // R2 R7 restart redoes the interrupted descriptor
    wr_reg(3'd0, 32'h1);
    wr_reg(3'd2, 32'h0);
    wait_quiet("R2 restart completes");
    ok = 1'b1;
    for (int k = 0; k < 16; k++) if (mem[768+k] !== PAT + 32'(640+k)) ok = 1'b0;
    chk("R2 restarted copy complete", {31'd0, ok}, 32'd1);
    chk("R6 restarted flags writeback", mem[80], 32'h0);
    rd_reg(3'd1, d); chk("R6 pointer after restart", d, 32'h100);
    rd_reg(3'd5, d); chk("R11 residual zero after completion", d, 32'h0);

    chk("R12 request held until ack", 32'(hold_bad), 32'd0);
    finish_run();
  end
endmodule